// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Locked Arbitration

This block gathers a parameterised number of level-sensitive interrupt lines (up to 128, in banks of 32) and drives a single interrupt request towards a processor. Software reaches it through a plain 32-bit register port: address, write strobe, write data, read strobe and read data. Each source can be masked or unmasked with a pair of write-one registers per bank. Each source can also be forced pending by software, and that forced state is combined with its hardware line.

When one or more unmasked sources are pending, a fixed-priority arbiter picks the lowest-numbered one. The choice is held until software issues an end-of-interrupt command. Software reads the active-source register to learn the number. If nothing is selected, or the selected source has gone away, that read returns a spurious marker instead. A soft reset returns all programmable state to its reset values and reports its completion through a status bit. A threshold register and a revision register complete the set.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, every source is masked (reading a mask-set register returns all ones), every software-pending bit reads 0, the threshold reads 0xFF, status bit 0 reads 1 and irq_o is low.
- R2: Reading offset 0x00 returns the major revision parameter in bits 7:4 and the minor revision parameter in bits 3:0, with zeros above.
- R3: A write to mask-set (0x8C + 0x20*n) sets each mask bit written as 1 and a write to mask-clear (0x88 + 0x20*n) clears each mask bit written as 1. Bits written as 0 are unchanged. Reading either address returns the current mask of bank n.
- R4: Source s is controlled by bit s&31 of the registers of bank s>>5.
- R5: A source is pending when its line or its software-pending bit is 1 and it is unmasked. Software-pending bits are set by writing ones to 0x90 + 0x20*n and cleared by writing ones to 0x94 + 0x20*n. Reading either address returns the bank's software-pending bits.
- R6: With no selection held, the lowest-numbered pending source is selected at the next clock edge, and irq_o is high from then on.
- R7: A selection and irq_o are held until a write with bit 0 set reaches the control register (0x48), even if a lower-numbered source becomes pending. irq_o is low in the cycle after that write, and arbitration resumes at the following edge.
- R8: Reading 0x40 returns the selected number in bits 6:0 with zeros above while the selected source is still pending. Otherwise it returns 0x00000080 (bit 7 set marks a spurious read).
- R9: Writing bit 1 of 0x10 starts a soft reset. Status bit 0 at 0x14 reads 0 for SRST_CYCLES cycles and then 1, and the state of R1 is restored, including release of any selection.
- R10: The threshold register at 0x68 holds the low 8 bits written, reads back with zeros above and has no effect on arbitration.
- R11: Reads of unmapped offsets (including bank offsets beyond the last bank and the gaps between bank groups) return 0, and writes to them change no state.
- R12: Read data appears on rdata_o in the cycle after the read strobe and is 0 in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines, active high |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, one cycle after rd_en_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with NUM_SRC = 128, so four banks exist. A source in the top bank (96) can therefore compete against sources in bank 0, and bank offsets just past the last bank can be checked as unmapped. SRST_CYCLES = 3 keeps the busy window short but still long enough for the status bit to be seen low. A distinct revision pair (4, 3) makes a swap of the two revision fields visible.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int OFS_REV       = 'h00;
  localparam int OFS_SYSCFG    = 'h10;
  localparam int OFS_STATUS    = 'h14;
  localparam int OFS_ACTIVE    = 'h40;
  localparam int OFS_CTRL      = 'h48;
  localparam int OFS_THRESH    = 'h68;
  localparam int OFS_BANK_BASE = 'h88;
  localparam int BANK_STRIDE_L2 = 5;
  localparam int DATA_W        = 32;
  localparam int ACT_W         = 7;
  localparam logic [31:0] SPURIOUS_VAL = 32'h0000_0080;

  typedef enum logic [1:0] {
    SUB_MASK_CLR = 2'd0,
    SUB_MASK_SET = 2'd1,
    SUB_PEND_SET = 2'd2,
    SUB_PEND_CLR = 2'd3
  } bank_sub_e;
endpackage

// File: rtl/lic_bank.sv
module lic_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic         mclr_we,
  input  logic         mset_we,
  input  logic         pset_we,
  input  logic         pclr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] swp_q
);
  logic [W-1:0] mask_d;
  logic [W-1:0] swp_d;

  always_comb begin
    mask_d = mask_q;
    swp_d  = swp_q;
    if (clr_all) begin
      mask_d = '1;
      swp_d  = '0;
    end else begin
      if (mset_we) mask_d = mask_q | wdata;
      if (mclr_we) mask_d = mask_q & ~wdata;
      if (pset_we) swp_d  = swp_q | wdata;
      if (pclr_we) swp_d  = swp_q & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      swp_q  <= '0;
    end else begin
      mask_q <= mask_d;
      swp_q  <= swp_d;
    end
  end
endmodule

// File: rtl/lic_prio_arb.sv
module lic_prio_arb #(
  parameter int N  = 128,
  parameter int IW = 7
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lic_srst_seq.sv
module lic_srst_seq #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = (CYC > 1) ? $clog2(CYC + 1) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lic_pkg::*;
#(
  parameter int         NUM_SRC     = 128,
  parameter int         ADDR_W      = 12,
  parameter int         SRST_CYCLES = 4,
  parameter logic [3:0] REV_MAJOR   = 4'h1,
  parameter logic [3:0] REV_MINOR   = 4'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [31:0]        wdata_i,
  input  logic               rd_en_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o
);
  localparam int NB = NUM_SRC / DATA_W;
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;

  // address decode
  logic [ADDR_W-1:0] rel;
  logic              in_bank;
  logic [BW-1:0]     bank_idx;
  bank_sub_e         sub;
  logic              srst_busy;
  logic              wr_ok;

  assign rel      = addr_i - ADDR_W'(OFS_BANK_BASE);
  assign in_bank  = (addr_i >= ADDR_W'(OFS_BANK_BASE))
                  && (rel[ADDR_W-1:BANK_STRIDE_L2] < (ADDR_W-BANK_STRIDE_L2)'(NB))
                  && (rel[4] == 1'b0) && (rel[1:0] == 2'b00);
  assign bank_idx = (NB > 1) ? rel[BANK_STRIDE_L2 +: BW] : '0;
  assign sub      = bank_sub_e'(rel[3:2]);
  assign wr_ok    = wr_en_i && !srst_busy;

  logic hit_ctrl, hit_sys, hit_thr;
  assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
  assign hit_sys  = (addr_i == ADDR_W'(OFS_SYSCFG));
  assign hit_thr  = (addr_i == ADDR_W'(OFS_THRESH));

  logic eoi_we, srst_start, thr_we;
  assign eoi_we     = wr_ok && hit_ctrl && wdata_i[0];
  assign srst_start = wr_ok && hit_sys && wdata_i[1];
  assign thr_we     = wr_ok && hit_thr;

  // soft reset sequencer
  lic_srst_seq #(.CYC(SRST_CYCLES)) srst_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (srst_start),
    .busy  (srst_busy)
  );

  // per-bank mask and software-pending state
  logic [NUM_SRC-1:0] mask_flat;
  logic [NUM_SRC-1:0] swp_flat;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel_b;
    assign sel_b = wr_ok && in_bank && (bank_idx == BW'(b));
    lic_bank #(.W(DATA_W)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (srst_busy),
      .mclr_we (sel_b && (sub == SUB_MASK_CLR)),
      .mset_we (sel_b && (sub == SUB_MASK_SET)),
      .pset_we (sel_b && (sub == SUB_PEND_SET)),
      .pclr_we (sel_b && (sub == SUB_PEND_CLR)),
      .wdata   (wdata_i),
      .mask_q  (mask_flat[b*DATA_W +: DATA_W]),
      .swp_q   (swp_flat[b*DATA_W +: DATA_W])
    );
  end

  // pending vector and arbitration
  logic [NUM_SRC-1:0] pend_vec;
  logic               arb_found;
  logic [IW-1:0]      arb_idx;

  assign pend_vec = (src_i | swp_flat) & ~mask_flat;

  lic_prio_arb #(.N(NUM_SRC), .IW(IW)) arb_i (
    .req   (pend_vec),
    .found (arb_found),
    .idx   (arb_idx)
  );

  // selection lock
  logic          locked_q, locked_d;
  logic [IW-1:0] sel_q, sel_d;

  always_comb begin
    locked_d = locked_q;
    sel_d    = sel_q;
    if (srst_busy) begin
      locked_d = 1'b0;
      sel_d    = '0;
    end else if (eoi_we) begin
      locked_d = 1'b0;
    end else if (!locked_q && arb_found) begin
      locked_d = 1'b1;
      sel_d    = arb_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      sel_q    <= '0;
    end else begin
      locked_q <= locked_d;
      sel_q    <= sel_d;
    end
  end

  assign irq_o = locked_q;

  // threshold register
  logic [7:0] thr_q, thr_d;

  always_comb begin
    thr_d = thr_q;
    if (srst_busy)   thr_d = 8'hFF;
    else if (thr_we) thr_d = wdata_i[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= 8'hFF;
    else        thr_q <= thr_d;
  end

  // read path
  logic [DATA_W-1:0] bank_mask_rd, bank_swp_rd;
  logic              sel_live;
  logic [31:0]       rd_d, rdata_q;

  always_comb begin
    bank_mask_rd = '0;
    bank_swp_rd  = '0;
    for (int b = 0; b < NB; b++) begin
      if (bank_idx == BW'(b)) begin
        bank_mask_rd = mask_flat[b*DATA_W +: DATA_W];
        bank_swp_rd  = swp_flat[b*DATA_W +: DATA_W];
      end
    end
  end

  assign sel_live = locked_q && pend_vec[sel_q];

  always_comb begin
    rd_d = '0;
    if (addr_i == ADDR_W'(OFS_REV)) begin
      rd_d = {24'h0, REV_MAJOR, REV_MINOR};
    end else if (addr_i == ADDR_W'(OFS_STATUS)) begin
      rd_d = {31'h0, !srst_busy};
    end else if (addr_i == ADDR_W'(OFS_ACTIVE)) begin
      rd_d = sel_live ? {{(32-ACT_W){1'b0}}, ACT_W'(sel_q)} : SPURIOUS_VAL;
    end else if (hit_thr) begin
      rd_d = {24'h0, thr_q};
    end else if (in_bank) begin
      if ((sub == SUB_MASK_CLR) || (sub == SUB_MASK_SET)) rd_d = bank_mask_rd;
      else                                                rd_d = bank_swp_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_d;
    else              rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int NUM_SRC = 128,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_en_i,
  input logic [31:0]        wdata_i,
  input logic               rd_en_i,
  input logic [31:0]        rdata_o,
  input logic               irq_o,
  input logic               srst_busy,
  input logic [NUM_SRC-1:0] mask_flat,
  input logic [NUM_SRC-1:0] pend_vec,
  input logic [6:0]         sel_num
);
  logic eoi_w;
  assign eoi_w = wr_en_i && !srst_busy && (addr_i == ADDR_W'('h48)) && wdata_i[0];

  // R7: request held until end-of-interrupt or soft reset
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !eoi_w && !srst_busy |=> irq_o);

  // R7: selected number stable while held
  assert_sel_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !eoi_w && !srst_busy |=> $stable(sel_num));

  // R7: end-of-interrupt releases the request
  assert_eoi_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_w |=> !irq_o);

  // R6, R5: request rises only with a pending unmasked source
  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|pend_vec));

  // R9: soft reset masks every source
  assert_srst_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |=> (&mask_flat));

  // R8: active read is a number or exactly the spurious marker
  assert_active_fmt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && (addr_i == ADDR_W'('h40)) |=>
      (rdata_o[7] ? (rdata_o == 32'h80) : (rdata_o[31:7] == '0)));

  // R12: no read strobe, zero read data
  assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> (rdata_o == '0));
endmodule

bind lvl_irq_ctrl lic_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wdata_i   (wdata_i),
  .rd_en_i   (rd_en_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .srst_busy (srst_busy),
  .mask_flat (mask_flat),
  .pend_vec  (pend_vec),
  .sel_num   (7'(sel_q))
);

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 128;
  localparam int AW   = 12;
  localparam int SRC  = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_i = '0;
  logic [AW-1:0]   addr_i = '0;
  logic            wr_en_i = 1'b0;
  logic [31:0]     wdata_i = '0;
  logic            rd_en_i = 1'b0;
  logic [31:0]     rdata_o;
  logic            irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl_irq_ctrl #(
    .NUM_SRC(NSRC), .ADDR_W(AW), .SRST_CYCLES(SRC),
    .REV_MAJOR(4'h4), .REV_MINOR(4'h3)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rd_en_i(rd_en_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [AW-1:0] a_mclr(int n); return AW'('h88 + 'h20*n); endfunction
  function automatic logic [AW-1:0] a_mset(int n); return AW'('h8C + 'h20*n); endfunction
  function automatic logic [AW-1:0] a_pset(int n); return AW'('h90 + 'h20*n); endfunction
  function automatic logic [AW-1:0] a_pclr(int n); return AW'('h94 + 'h20*n); endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cleanup();
    @(negedge clk);
    src_i = '0;
    for (int b = 0; b < 4; b++) begin
      wr(a_mset(b), 32'hFFFF_FFFF);
      wr(a_pclr(b), 32'hFFFF_FFFF);
    end
    wr(12'h48, 32'h1);
    idle(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int b = 0; b < 4; b++) begin
      rd(a_mset(b), d); check("R1 mask reset", d, 32'hFFFF_FFFF);
    end
    rd(a_pset(0), d);    check("R1 swpend reset", d, 32'h0);
    rd(12'h68, d);       check("R1 threshold reset", d, 32'hFF);
    rd(12'h14, d);       check("R1 status done", d, 32'h1);
    check("R1 irq low", {31'h0, irq_o}, 32'h0);
    rd(12'h40, d);       check("R8 spurious with nothing", d, 32'h80);
    idle(1);
    check("R12 idle rdata zero", rdata_o, 32'h0);
    src_i = '1;
    idle(3);
    check("R1 masked lines give no irq", {31'h0, irq_o}, 32'h0);
    src_i = '0;
  endtask

  task automatic t_revision();
    logic [31:0] d;
    rd(12'h00, d); check("R2 revision", d, 32'h43);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(a_mclr(1), 32'h5);
    rd(a_mset(1), d); check("R3 w1c mask", d, 32'hFFFF_FFFA);
    wr(a_mclr(1), 32'h0);
    rd(a_mset(1), d); check("R3 zero write no effect", d, 32'hFFFF_FFFA);
    wr(a_mset(1), 32'h1);
    rd(a_mclr(1), d); check("R3 w1s mask, read via clear addr", d, 32'hFFFF_FFFB);
    rd(a_mset(0), d); check("R3 other bank untouched", d, 32'hFFFF_FFFF);
    cleanup();
  endtask

  task automatic t_mapping();
    logic [31:0] d;
    @(negedge clk); src_i[70] = 1'b1;
    wr(a_mclr(2), 32'h1 << 6);
    idle(1);
    check("R4 source 70 raises irq", {31'h0, irq_o}, 32'h1);
    rd(12'h40, d); check("R4 source 70 number", d, 32'd70);
    cleanup();
  endtask

  task automatic t_swpend();
    logic [31:0] d;
    wr(a_mclr(0), 32'h1 << 9);
    check("R5 unmasked idle no irq", {31'h0, irq_o}, 32'h0);
    wr(a_pset(0), 32'h1 << 9);
    idle(1);
    check("R5 sw pending raises irq", {31'h0, irq_o}, 32'h1);
    rd(a_pclr(0), d); check("R5 sw pending readback", d, 32'h200);
    rd(12'h40, d);   check("R5 sw pending number", d, 32'd9);
    wr(a_pclr(0), 32'h1 << 9);
    rd(12'h40, d);   check("R8 dropped source is spurious", d, 32'h80);
    wr(12'h48, 32'h1);
    check("R7 eoi drops irq", {31'h0, irq_o}, 32'h0);
    idle(2);
    check("R5 nothing pending after clear", {31'h0, irq_o}, 32'h0);
    cleanup();
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(a_mclr(0), 32'h28);
    wr(a_mclr(3), 32'h1);
    @(negedge clk);
    src_i[3] = 1'b1; src_i[5] = 1'b1; src_i[96] = 1'b1;
    idle(2);
    rd(12'h40, d); check("R6 lowest wins (3)", d, 32'd3);
    @(negedge clk); src_i[3] = 1'b0;
    wr(12'h48, 32'h1);
    rd(12'h40, d); check("R6 next lowest (5)", d, 32'd5);
    @(negedge clk); src_i[5] = 1'b0;
    wr(12'h48, 32'h1);
    rd(12'h40, d); check("R6 top bank source (96)", d, 32'd96);
    @(negedge clk); src_i[96] = 1'b0;
    wr(12'h48, 32'h1);
    idle(2);
    check("R6 irq low when nothing left", {31'h0, irq_o}, 32'h0);
    cleanup();
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(a_mclr(0), 32'h14);
    @(negedge clk); src_i[4] = 1'b1;
    idle(2);
    rd(12'h40, d); check("R7 first selection 4", d, 32'd4);
    @(negedge clk); src_i[2] = 1'b1;
    idle(3);
    rd(12'h40, d); check("R7 held despite lower source", d, 32'd4);
    check("R7 irq held", {31'h0, irq_o}, 32'h1);
    wr(12'h48, 32'h2);
    rd(12'h40, d); check("R7 bit0 clear is not eoi", d, 32'd4);
    wr(12'h48, 32'h1);
    check("R7 irq low after eoi", {31'h0, irq_o}, 32'h0);
    idle(1);
    check("R7 irq back after eoi", {31'h0, irq_o}, 32'h1);
    rd(12'h40, d); check("R7 rearbitrated to 2", d, 32'd2);
    cleanup();
  endtask

  task automatic t_softreset();
    logic [31:0] d;
    wr(a_mclr(0), 32'h2);
    wr(a_pset(0), 32'h2);
    wr(12'h68, 32'h22);
    idle(1);
    check("R9 pre irq", {31'h0, irq_o}, 32'h1);
    wr(12'h10, 32'h2);
    rd(12'h14, d); check("R9 status busy", d, 32'h0);
    check("R9 irq released", {31'h0, irq_o}, 32'h0);
    idle(6);
    rd(12'h14, d);   check("R9 status done", d, 32'h1);
    rd(a_mset(0), d); check("R9 mask restored", d, 32'hFFFF_FFFF);
    rd(a_pset(0), d); check("R9 swpend cleared", d, 32'h0);
    rd(12'h68, d);   check("R9 threshold restored", d, 32'hFF);
    check("R9 irq stays low", {31'h0, irq_o}, 32'h0);
    cleanup();
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    wr(12'h68, 32'hFFFF_FF37);
    rd(12'h68, d); check("R10 threshold low byte", d, 32'h37);
    wr(12'h68, 32'h0);
    rd(12'h68, d); check("R10 threshold zero", d, 32'h0);
    @(negedge clk); src_i[8] = 1'b1;
    wr(a_mclr(0), 32'h100);
    idle(1);
    rd(12'h40, d); check("R10 threshold no filtering", d, 32'd8);
    cleanup();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(12'h44, 32'hFFFF_FFFF);
    rd(12'h44, d); check("R11 unmapped read zero", d, 32'h0);
    wr(12'h108, 32'hFFFF_FFFF);
    rd(12'h108, d); check("R11 beyond last bank", d, 32'h0);
    wr(12'h98, 32'hFFFF_FFFF);
    rd(12'h98, d); check("R11 bank gap read zero", d, 32'h0);
    rd(a_mset(0), d); check("R11 mask untouched", d, 32'hFFFF_FFFF);
    rd(a_pset(0), d); check("R11 swpend untouched", d, 32'h0);
    rd(a_mset(3), d); check("R11 top bank untouched", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_revision();
    t_mask();
    t_mapping();
    t_swpend();
    t_priority();
    t_lock();
    t_softreset();
    t_threshold();
    t_unmapped();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got %0d exp %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule